// File: doc/BRIEF.md
# Chainable Up-Counting Timer with Selectable Trigger Output

This block is a general-purpose timer whose main job is to produce a single trigger line (`trig_out`) that other timers or data converters on the chip can listen to. A clock-enable prescaler feeds a 16-bit up-counter that wraps at a programmable reload value. Each wrap is an update event. Software can also force an update event through a strobe register. A 3-bit selector chooses which internal event or level drives the trigger line. The choices are an update pulse, the counter-enable level, a pulse when the channel-1 compare flag is about to be set, the software strobe itself, and four output-compare reference levels.

Configuration goes over a simple strobe bus. A write takes effect at the clock edge where `wr_en` is high. A read returns data on `rdata` one cycle after `rd_en`. An update interrupt request is raised from a sticky status flag when it is enabled. Chaining works like this: a downstream timer counting the update pulses of this one sees this timer as a prescaler.

Register map, with the 4-bit word address in brackets:
- CTRL [0]: bit0 is the counter enable, bit1 is the reload preload enable.
- MODE [1]: bits 2:0 are the trigger select.
- IRQEN [2]: bit0 is the update interrupt enable.
- STATUS [3]: bit0 is the update flag, bit1 is the compare-1 flag.
- EVGEN [4]: write-only, bit0 is the update strobe.
- PSC [5]: prescaler value.
- RELOAD [6]: reload value.
- COUNT [7]: read-only counter value.
- CMP1 to CMP4 [8..11]: compare values.

Top module: `trig_timer`

## Requirements
- R1: While `rst_n` is low at a clock edge, all registers clear. After reset, `trig_out`, `irq` and every `oc_ref` bit are 0, and COUNT reads 0.
- R2: With an active prescaler value P, an enabled counter advances once every P+1 clock cycles. A value written to PSC becomes active only at the next update event.
- R3: The counter wraps from the active reload value R to 0, which gives a period of R+1 counter steps. Each wrap is an update event.
- R4: While CTRL bit0 is 0, the counter holds its value and is not cleared.
- R5: With CTRL bit1 set, a RELOAD write takes effect only at the next update event. With CTRL bit1 clear, it takes effect at once.
- R6: Writing 1 to EVGEN bit0 forces an update event. The counter and prescaler restart from 0, and the buffered PSC and RELOAD values become active. Writing 0 there has no effect.
- R7: Every update event sets STATUS bit0. `irq` is high while STATUS bit0 and IRQEN bit0 are both 1. Writing 0 to a STATUS bit clears it and writing 1 leaves it unchanged. A flag set in the same cycle as the write wins.
- R8: STATUS bit1 becomes 1 in the cycle after the counter is loaded with a value equal to CMP1.
- R9: `oc_ref[i]` is high exactly while COUNT is below compare register i+1.
- R10: `trig_out` is the registered copy, one cycle later, of the source selected by MODE. The encodings are: 0 = update strobe pulse, 1 = counter-enable level, 2 = update event pulse, 3 = compare-1 set pulse (high in the same cycle STATUS bit1 rises), 4..7 = `oc_ref[0..3]`.
- R11: A read returns the addressed register on `rdata` one cycle after `rd_en`. EVGEN reads 0 and RELOAD reads the last written value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | 4 | Word address |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data, valid one cycle after rd_en |
| trig_out | output | 1 | Selected trigger output |
| irq | output | 1 | Update interrupt request |
| oc_ref | output | 4 | Output-compare reference levels |

## Verification
A behavioural reference model runs beside the design and is compared on every clock. Directed checks then target the timing that is easy to get wrong:
- Measuring trigger intervals shows that a prescaler or reload off by one changes the period from (P+1)(R+1) cycles.
- A preloaded reload that is applied too early shortens the interval straight after the write.
- Compare-pulse mode must line the pulse up with the flag edge, and a design that fires a cycle late would disagree with both the model and the flag read.
- The flag write semantics and the strobe's zero-write are checked through `irq` and read-back. A wrong implementation would either clear on a written 1 or restart the counter on a written 0.

// File: rtl/tt_pkg.sv
// Shared constants for the chainable timer: register addresses and trigger sources.
package tt_pkg;
    localparam int ADDR_W = 4;
    localparam int N_OC   = 4;

    localparam logic [ADDR_W-1:0] A_CTRL   = 4'd0;
    localparam logic [ADDR_W-1:0] A_MODE   = 4'd1;
    localparam logic [ADDR_W-1:0] A_IRQEN  = 4'd2;
    localparam logic [ADDR_W-1:0] A_STATUS = 4'd3;
    localparam logic [ADDR_W-1:0] A_EVGEN  = 4'd4;
    localparam logic [ADDR_W-1:0] A_PSC    = 4'd5;
    localparam logic [ADDR_W-1:0] A_RELOAD = 4'd6;
    localparam logic [ADDR_W-1:0] A_COUNT  = 4'd7;
    localparam logic [ADDR_W-1:0] A_CMP0   = 4'd8;

    typedef enum logic [2:0] {
        TS_SWUPD  = 3'd0,
        TS_ENABLE = 3'd1,
        TS_UPDATE = 3'd2,
        TS_CMPPLS = 3'd3,
        TS_OCREF1 = 3'd4,
        TS_OCREF2 = 3'd5,
        TS_OCREF3 = 3'd6,
        TS_OCREF4 = 3'd7
    } trig_src_e;
endpackage

// File: rtl/tt_regs.sv
// Register file of the timer.
// Holds the configuration, the sticky flags and the read-data register.
// Assumes a single-cycle write strobe; flag sets win over same-cycle clears.
module tt_regs
    import tt_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int CNT_W  = 16,
    parameter int PSC_W  = 16
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_en,
    input  logic                         rd_en,
    input  logic [ADDR_W-1:0]            addr,
    input  logic [DATA_W-1:0]            wdata,
    input  logic                         uev,
    input  logic                         cc1_hit,
    input  logic [CNT_W-1:0]             count,
    output logic                         cnt_en,
    output logic                         arpe,
    output logic [2:0]                   trig_sel,
    output logic                         uie,
    output logic                         uif,
    output logic                         ccf,
    output logic                         ug,
    output logic [PSC_W-1:0]             psc_reg,
    output logic [CNT_W-1:0]             reload_reg,
    output logic [N_OC-1:0][CNT_W-1:0]   cmp,
    output logic [DATA_W-1:0]            rdata
);
    localparam int CMP_LAST = int'(A_CMP0) + N_OC - 1;

    // Decode of the write-only update strobe
    assign ug = wr_en && (addr == A_EVGEN) && wdata[0];

    // Configuration register writes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_en     <= 1'b0;
            arpe       <= 1'b0;
            trig_sel   <= 3'd0;
            uie        <= 1'b0;
            psc_reg    <= '0;
            reload_reg <= '0;
        end else if (wr_en) begin
            case (addr)
                A_CTRL:   begin cnt_en <= wdata[0]; arpe <= wdata[1]; end
                A_MODE:   trig_sel   <= wdata[2:0];
                A_IRQEN:  uie        <= wdata[0];
                A_PSC:    psc_reg    <= wdata[PSC_W-1:0];
                A_RELOAD: reload_reg <= wdata[CNT_W-1:0];
                default:  ;
            endcase
        end
    end

    // Compare registers, one per channel
    for (genvar i = 0; i < N_OC; i++) begin : g_cmp
        always_ff @(posedge clk) begin
            if (!rst_n)
                cmp[i] <= '0;
            else if (wr_en && addr == (A_CMP0 + ADDR_W'(i)))
                cmp[i] <= wdata[CNT_W-1:0];
        end
    end

    // Sticky flags: event sets, written zero clears
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            uif <= 1'b0;
            ccf <= 1'b0;
        end else begin
            if (wr_en && addr == A_STATUS) begin
                uif <= (uif & wdata[0]) | uev;
                ccf <= (ccf & wdata[1]) | cc1_hit;
            end else begin
                uif <= uif | uev;
                ccf <= ccf | cc1_hit;
            end
        end
    end

    // Registered read path
    always_ff @(posedge clk) begin
        if (!rst_n)
            rdata <= '0;
        else if (rd_en) begin
            rdata <= '0;
            case (addr)
                A_CTRL:   rdata <= DATA_W'({arpe, cnt_en});
                A_MODE:   rdata <= DATA_W'(trig_sel);
                A_IRQEN:  rdata <= DATA_W'(uie);
                A_STATUS: rdata <= DATA_W'({ccf, uif});
                A_PSC:    rdata <= DATA_W'(psc_reg);
                A_RELOAD: rdata <= DATA_W'(reload_reg);
                A_COUNT:  rdata <= DATA_W'(count);
                default: begin
                    if (int'(addr) >= int'(A_CMP0) && int'(addr) <= CMP_LAST)
                        rdata <= DATA_W'(cmp[addr[1:0]]);
                end
            endcase
        end
    end
endmodule

// File: rtl/tt_counter.sv
// Prescaler and auto-reload up-counter.
// Generates the update event on wrap or strobe and the compare-1 hit.
// Assumes the buffered prescaler and reload values are loaded only on update.
module tt_counter #(
    parameter int CNT_W = 16,
    parameter int PSC_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cnt_en,
    input  logic             arpe,
    input  logic             ug,
    input  logic [PSC_W-1:0] psc_reg,
    input  logic [CNT_W-1:0] reload_reg,
    input  logic [CNT_W-1:0] cmp1,
    output logic [CNT_W-1:0] count,
    output logic             uev,
    output logic             cc1_hit
);
    logic [PSC_W-1:0] psc_act, psc_cnt;
    logic [CNT_W-1:0] reload_shadow, reload_act, count_nxt;
    logic             tick, ovf;

    // Reload in force: the shadow when buffered, otherwise the register
    assign reload_act = arpe ? reload_shadow : reload_reg;
    assign tick       = cnt_en && (psc_cnt == psc_act);
    assign ovf        = tick && (count == reload_act);
    assign uev        = ovf || ug;

    // Next counter value
    always_comb begin
        if (ug)        count_nxt = '0;
        else if (ovf)  count_nxt = '0;
        else if (tick) count_nxt = count + 1'b1;
        else           count_nxt = count;
    end

    assign cc1_hit = (ug || tick) && (count_nxt == cmp1);

    // Prescaler divider and counter state
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            psc_cnt <= '0;
            count   <= '0;
        end else begin
            count <= count_nxt;
            if (ug || tick)  psc_cnt <= '0;
            else if (cnt_en) psc_cnt <= psc_cnt + 1'b1;
        end
    end

    // Transfer of buffered values at each update event
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            psc_act       <= '0;
            reload_shadow <= '0;
        end else if (uev) begin
            psc_act       <= psc_reg;
            reload_shadow <= reload_reg;
        end
    end
endmodule

// File: rtl/tt_trgo.sv
// Output-compare reference levels and trigger-output selector.
// Assumes four compare channels so that selector codes 4..7 index them.
module tt_trgo
    import tt_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [2:0]                 trig_sel,
    input  logic                       ug,
    input  logic                       cnt_en,
    input  logic                       uev,
    input  logic                       cc1_hit,
    input  logic [CNT_W-1:0]           count,
    input  logic [N_OC-1:0][CNT_W-1:0] cmp,
    output logic [N_OC-1:0]            oc_ref,
    output logic                       trig_out
);
    logic src;

    // Reference level per channel
    for (genvar i = 0; i < N_OC; i++) begin : g_ref
        assign oc_ref[i] = (count < cmp[i]);
    end

    // Source multiplexer
    always_comb begin
        case (trig_src_e'(trig_sel))
            TS_SWUPD:  src = ug;
            TS_ENABLE: src = cnt_en;
            TS_UPDATE: src = uev;
            TS_CMPPLS: src = cc1_hit;
            default:   src = oc_ref[trig_sel[1:0]];
        endcase
    end

    // Registered trigger output
    always_ff @(posedge clk) begin
        if (!rst_n) trig_out <= 1'b0;
        else        trig_out <= src;
    end
endmodule

// File: rtl/trig_timer.sv
// Top of the chainable timer.
// Wires registers, counter and trigger selector together and forms the interrupt.
module trig_timer
    import tt_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int CNT_W  = 16,
    parameter int PSC_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [3:0]        addr,
    input  logic [15:0]       wdata,
    output logic [15:0]       rdata,
    output logic              trig_out,
    output logic              irq,
    output logic [3:0]        oc_ref
);
    logic                       cnt_en, arpe, uie, uif, ccf, ug, uev, cc1_hit;
    logic [2:0]                 trig_sel;
    logic [PSC_W-1:0]           psc_reg;
    logic [CNT_W-1:0]           reload_reg, count;
    logic [N_OC-1:0][CNT_W-1:0] cmp;

    tt_regs #(.DATA_W(DATA_W), .CNT_W(CNT_W), .PSC_W(PSC_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .uev(uev), .cc1_hit(cc1_hit), .count(count),
        .cnt_en(cnt_en), .arpe(arpe), .trig_sel(trig_sel), .uie(uie),
        .uif(uif), .ccf(ccf), .ug(ug), .psc_reg(psc_reg),
        .reload_reg(reload_reg), .cmp(cmp), .rdata(rdata)
    );

    tt_counter #(.CNT_W(CNT_W), .PSC_W(PSC_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .arpe(arpe), .ug(ug),
        .psc_reg(psc_reg), .reload_reg(reload_reg), .cmp1(cmp[0]),
        .count(count), .uev(uev), .cc1_hit(cc1_hit)
    );

    tt_trgo #(.CNT_W(CNT_W)) u_trgo (
        .clk(clk), .rst_n(rst_n), .trig_sel(trig_sel), .ug(ug),
        .cnt_en(cnt_en), .uev(uev), .cc1_hit(cc1_hit), .count(count),
        .cmp(cmp), .oc_ref(oc_ref), .trig_out(trig_out)
    );

    // Interrupt request from flag and enable
    assign irq = uif && uie;
endmodule

// File: rtl/tt_checker.sv
// Temporal properties of the chainable timer, attached to the top by bind.
module tt_checker #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             trig_out,
    input logic             irq,
    input logic             cnt_en,
    input logic             ug,
    input logic             uev,
    input logic             cc1_hit,
    input logic             uif,
    input logic             ccf,
    input logic [2:0]       trig_sel,
    input logic [CNT_W-1:0] count
);
    assert_reset_quiet_R1: assert property (@(posedge clk)
        !rst_n |=> (!trig_out && !irq));

    assert_wrap_to_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        uev |=> (count == '0));

    assert_hold_when_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!cnt_en && !ug) |=> $stable(count));

    assert_strobe_restart_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ug |=> (count == '0 && uif));

    assert_update_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
        uev |=> uif);

    assert_cmp_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cc1_hit |=> ccf);

    assert_update_trig_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_sel == 3'd2 && uev) |=> trig_out);
endmodule

bind trig_timer tt_checker #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .trig_out(trig_out), .irq(irq),
    .cnt_en(cnt_en), .ug(ug), .uev(uev), .cc1_hit(cc1_hit), .uif(uif),
    .ccf(ccf), .trig_sel(trig_sel), .count(count)
);

// File: tb/trig_timer_test.sv
// Bench: behavioural reference model compared every clock, plus directed checks.
module trig_timer_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0, rd_en = 1'b0;
    logic [3:0]  addr = '0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic        trig_out, irq;
    logic [3:0]  oc_ref;

    int n_chk = 0, n_fail = 0, cycles = 0;
    bit done = 0;

    always #2 clk = ~clk;

    trig_timer uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .trig_out(trig_out), .irq(irq), .oc_ref(oc_ref)
    );

    // Reference model state
    int m_en, m_arpe, m_sel, m_uie, m_uif, m_ccf, m_psc, m_rld, m_rldsh;
    int m_pact, m_pcnt, m_cnt, m_trig, m_rdata;
    int m_cmp [4];

    function automatic int model_read(int a);
        case (a)
            0: return m_en | (m_arpe << 1);
            1: return m_sel;
            2: return m_uie;
            3: return m_uif | (m_ccf << 1);
            5: return m_psc;
            6: return m_rld;
            7: return m_cnt;
            8, 9, 10, 11: return m_cmp[a-8];
            default: return 0;
        endcase
    endfunction

    // Model step at each rising edge
    always @(posedge clk) begin
        if (!rst_n) begin
            m_en = 0; m_arpe = 0; m_sel = 0; m_uie = 0; m_uif = 0; m_ccf = 0;
            m_psc = 0; m_rld = 0; m_rldsh = 0; m_pact = 0; m_pcnt = 0;
            m_cnt = 0; m_trig = 0; m_rdata = 0;
            foreach (m_cmp[k]) m_cmp[k] = 0;
        end else begin
            int sw, rl, tk, ov, ue, nc, hit, src, a, d;
            a = int'(addr); d = int'(wdata);
            sw = (wr_en && a == 4 && d[0]) ? 1 : 0;
            rl = m_arpe ? m_rldsh : m_rld;
            tk = (m_en && m_pcnt == m_pact) ? 1 : 0;
            ov = (tk && m_cnt == rl) ? 1 : 0;
            ue = ov | sw;
            if (sw || ov) nc = 0;
            else if (tk)  nc = (m_cnt + 1) % 65536;
            else          nc = m_cnt;
            hit = ((sw || tk) && nc == m_cmp[0]) ? 1 : 0;
            case (m_sel)
                0: src = sw;
                1: src = m_en;
                2: src = ue;
                3: src = hit;
                default: src = (m_cnt < m_cmp[m_sel-4]) ? 1 : 0;
            endcase
            if (rd_en) m_rdata = model_read(a);
            m_trig = src;
            if (sw || tk) m_pcnt = 0; else if (m_en) m_pcnt = m_pcnt + 1;
            if (ue) begin m_pact = m_psc; m_rldsh = m_rld; end
            m_cnt = nc;
            if (wr_en && a == 3) begin
                m_uif = (m_uif & d[0]) | ue;
                m_ccf = (m_ccf & d[1]) | hit;
            end else begin
                m_uif = m_uif | ue;
                m_ccf = m_ccf | hit;
            end
            if (wr_en) begin
                case (a)
                    0: begin m_en = d[0]; m_arpe = d[1]; end
                    1: m_sel = d[2:0];
                    2: m_uie = d[0];
                    5: m_psc = d;
                    6: m_rld = d;
                    8, 9, 10, 11: m_cmp[a-8] = d;
                    default: ;
                endcase
            end
        end
    end

    task automatic check(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at cycle %0d", tag, act, exp, cycles);
        end
    endtask

    // Per-clock comparison against the model, away from the rising edge
    always @(negedge clk) begin
        cycles++;
        if (rst_n && !done) begin
            int ref_oc;
            ref_oc = 0;
            for (int k = 0; k < 4; k++) if (m_cnt < m_cmp[k]) ref_oc |= (1 << k);
            check("R10 model trig_out", int'(trig_out), m_trig);
            check("R7 model irq", int'(irq), (m_uif && m_uie) ? 1 : 0);
            check("R9 model oc_ref", int'(oc_ref), ref_oc);
            check("R11 model rdata", int'(rdata), m_rdata);
        end
    end

    task automatic wr(int a, int d);
        @(negedge clk);
        wr_en = 1'b1; addr = 4'(a); wdata = 16'(d);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(int a, output int v);
        @(negedge clk);
        rd_en = 1'b1; addr = 4'(a);
        @(negedge clk);
        rd_en = 1'b0;
        v = int'(rdata);
    endtask

    // Cycles from one trigger pulse to the next
    task automatic measure(output int n);
        int g;
        g = 0;
        @(negedge clk);
        while (!trig_out && g < 2000) begin @(negedge clk); g++; end
        n = 0;
        do begin @(negedge clk); n++; end while (!trig_out && n < 2000);
    endtask

    initial begin
        int v, v2, n;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 trig_out", int'(trig_out), 0);
        check("R1 irq", int'(irq), 0);
        check("R1 oc_ref", int'(oc_ref), 0);
        rd(7, v); check("R1 count", v, 0);

        // R3 update-mode period with no prescaling
        wr(6, 4); wr(1, 2); wr(0, 1);
        measure(n); check("R3 period R=4", n, 5);
        measure(n); check("R3 period repeat", n, 5);

        // R2 prescaler buffered, then loaded by strobe
        wr(5, 2); wr(6, 1); wr(4, 1);
        measure(n); check("R2 period P=2 R=1", n, 6);

        // R5 buffered reload applies only after next update
        wr(5, 0); wr(6, 4); wr(0, 3); wr(4, 1);
        measure(n); check("R5 period before", n, 5);
        wr(6, 9);
        measure(n); check("R5 period after update", n, 10);
        rd(6, v); check("R11 reload readback", v, 9);

        // R8 compare pulse mode
        wr(8, 2); wr(1, 3); wr(3, 0);
        measure(n); check("R8 compare pulse period", n, 10);
        rd(3, v); check("R8 compare flag", (v >> 1) & 1, 1);

        // R4 hold when disabled
        wr(0, 0);
        rd(7, v); repeat (8) @(negedge clk); rd(7, v2);
        check("R4 count frozen", v2, v);

        // R6 zero write to strobe ignored, one restarts
        wr(4, 0); rd(7, v2); check("R6 zero write ignored", v2, v);
        wr(3, 0); wr(4, 1); rd(7, v); check("R6 count restarted", v, 0);
        rd(3, v); check("R6 update flag from strobe", v & 1, 1);

        // R7 interrupt and flag semantics
        wr(2, 1); @(negedge clk); check("R7 irq raised", int'(irq), 1);
        wr(3, 3); check("R7 write one keeps", int'(irq), 1);
        wr(3, 0); check("R7 write zero clears", int'(irq), 0);
        rd(3, v); check("R7 flag cleared", v & 1, 0);

        // R9 reference level via trigger mode 5, counter frozen at 0
        wr(9, 5); wr(1, 5); @(negedge clk);
        check("R9 oc_ref[1]", int'(oc_ref[1]), 1);
        check("R9 trig from ref 2", int'(trig_out), 1);

        // R10 enable-level mode
        wr(1, 1); @(negedge clk); check("R10 enable level low", int'(trig_out), 0);
        wr(0, 1); @(negedge clk); check("R10 enable level high", int'(trig_out), 1);
        rd(1, v); check("R11 mode readback", v, 1);
        rd(4, v); check("R11 strobe reads zero", v, 0);

        // R10 strobe-pulse mode with running counter
        wr(1, 0); wr(4, 1); check("R10 strobe pulse", int'(trig_out), 1);
        @(negedge clk); check("R10 strobe pulse ends", int'(trig_out), 0);

        repeat (20) @(negedge clk);
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        done = 1;
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule